// File: doc/BRIEF.md
# System clock source switch with write-protected select

This block owns the choice of system clock source. Three sources are offered: the external crystal, the slow internal RC and the fast internal RC. The source is held as a 3-bit select code. The block drives a one-hot enable toward a glitch-free clock mux that sits outside it. The crystal leg goes to its high-speed or low-speed branch, as the crystal-mode input directs.

The select code is write-protected. A small sequencer watches a lock address. Only after three key bytes arrive there in the right order does it open the select for writing. Each switch request is checked against the stable flags of the target source and of the source now in use. If either flag is low, the switch is refused and a sticky failure flag is raised. Software clears that flag by writing 1 to it.

A status byte shows the failure flag and the live stable flag of every source.

Top module: `sclk_switch_top`

## Requirements
- R1: After reset the select code is 3'b111 (fast RC), the select is locked (`unlocked`=0) and the failure flag (status bit 7) is 0.
- R2: Writing 0x59, then 0x16, then 0x88 to the lock address, as three back-to-back register writes, sets `unlocked` to 1 in the cycle after the last write.
- R3: While the sequence is partly entered, a wrong byte at the lock address, or a write to any other address, returns the sequencer to its start. A later unlock then needs all three bytes again.
- R4: A write of any value to the lock address while unlocked clears `unlocked` in the next cycle.
- R5: A write to the select address while locked leaves the select code and the failure flag unchanged.
- R6: A write to the select address while unlocked is a valid request when `wr_data[2:0]` is 000, 011 or 111. If both the target's stable flag and the current source's stable flag are 1, the select code takes the new value in the next cycle.
- R7: If the target's or the current source's stable flag is 0 on a valid unlocked request, the failure flag is set and the select code keeps its old value.
- R8: Writes of the reserved codes 001, 010, 100, 101 and 110 change neither the select code nor the failure flag.
- R9: The failure flag stays set until the status address is written with `wr_data[7]`=1. A write with bit 7 = 0 leaves it set.
- R10: `src_en` is always one-hot:
  - bit 3 for code 111;
  - bit 2 for code 011;
  - bit 1 for code 000 with `xtal_mode`=2'b10 (low-speed crystal);
  - bit 0 for code 000 with any other crystal mode.
- R11: Status bits 0, 1 and 2 follow `src_stable[0]` (crystal), `src_stable[1]` (slow RC) and `src_stable[2]` (fast RC) in the same cycle. Bits 3 to 6 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| src_stable | input | 3 | Stable flags: bit 0 crystal, bit 1 slow RC, bit 2 fast RC |
| xtal_mode | input | 2 | Crystal mode, 2'b10 selects the low-speed crystal |
| sel_code | output | 3 | Current select code |
| src_en | output | 4 | One-hot mux enable: high-speed crystal, low-speed crystal, slow RC, fast RC |
| unlocked | output | 1 | Write protection is open |
| status | output | 8 | Bit 7 failure flag, bits 2..0 stable flags |

## Verification
The assertions watch, on every cycle, the properties that can be stated in a single step:
- `src_en` stays one-hot and the select code is never reserved;
- a locked or reserved write leaves the select alone;
- a refused switch keeps the code and raises the flag;
- the flag holds until it is cleared;
- a write at the lock address relocks.

Only the bench scenarios can show that the ordered three-byte sequence opens the select and that an interruption forces the whole sequence again. The same goes for the crystal branch following the mode input. These checks run against a behavioural reference compared on every clock.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam logic [2:0] CODE_XTAL = 3'b000;
  localparam logic [2:0] CODE_SLOW = 3'b011;
  localparam logic [2:0] CODE_FAST = 3'b111;
  localparam int         NUM_SRC   = 3;
  localparam int         NUM_LEG   = 4;
  localparam logic [1:0] XMODE_LOW = 2'b10;

  function automatic logic code_valid(input logic [2:0] code);
    return (code == CODE_XTAL) || (code == CODE_SLOW) || (code == CODE_FAST);
  endfunction

  function automatic logic code_stable(input logic [2:0] code,
                                       input logic [NUM_SRC-1:0] stb);
    logic r;
    case (code)
      CODE_XTAL: r = stb[0];
      CODE_SLOW: r = stb[1];
      CODE_FAST: r = stb[2];
      default:   r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sclk_unlock_seq.sv
module sclk_unlock_seq #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h40,
  parameter int NUM_KEYS = 3,
  parameter logic [NUM_KEYS-1:0][7:0] KEYS = {8'h88, 8'h16, 8'h59}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              unlocked
);
  localparam int SW = $clog2(NUM_KEYS + 1);
  localparam logic [SW-1:0] ST_IDLE = '0;
  localparam logic [SW-1:0] ST_OPEN = SW'(NUM_KEYS);

  logic [SW-1:0] stage_q, stage_d;
  logic          lock_hit;

  assign lock_hit = wr_en && (wr_addr == LOCK_ADDR);

  always_comb begin
    stage_d = stage_q;
    if (lock_hit) begin
      if (stage_q == ST_OPEN)
        stage_d = ST_IDLE;
      else if (wr_data == KEYS[stage_q])
        stage_d = stage_q + SW'(1);
      else
        stage_d = ST_IDLE;
    end else if (wr_en && (stage_q != ST_IDLE) && (stage_q != ST_OPEN)) begin
      stage_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= ST_IDLE;
    else        stage_q <= stage_d;
  end

  assign unlocked = (stage_q == ST_OPEN);
endmodule

// File: rtl/sclk_sel_ctrl.sv
module sclk_sel_ctrl
  import sclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_wr,
  input  logic [2:0]         sel_wdata,
  input  logic               fail_clr,
  input  logic               unlocked,
  input  logic [NUM_SRC-1:0] src_stable,
  output logic [2:0]         sel_q,
  output logic               fail_q
);
  logic [2:0] sel_d;
  logic       fail_d;
  logic       req_ok, tgt_ok, cur_ok, sel_ce;

  always_comb begin
    req_ok = sel_wr && unlocked && code_valid(sel_wdata);
    tgt_ok = code_stable(sel_wdata, src_stable);
    cur_ok = code_stable(sel_q, src_stable);
    sel_ce = req_ok && tgt_ok && cur_ok;
    sel_d  = sel_ce ? sel_wdata : sel_q;
    fail_d = fail_q;
    if (req_ok && !(tgt_ok && cur_ok)) fail_d = 1'b1;
    else if (fail_clr)                 fail_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= CODE_FAST;
      fail_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      fail_q <= fail_d;
    end
  end
endmodule

// File: rtl/sclk_src_decode.sv
module sclk_src_decode
  import sclk_pkg::*;
(
  input  logic [2:0]         sel,
  input  logic [1:0]         xtal_mode,
  output logic [NUM_LEG-1:0] src_en
);
  localparam logic [2:0] LEG_CODE [NUM_LEG] = '{CODE_XTAL, CODE_XTAL, CODE_SLOW, CODE_FAST};

  for (genvar g = 0; g < NUM_LEG; g++) begin : g_leg
    if (g == 0) begin : g_hx
      assign src_en[g] = (sel == LEG_CODE[g]) && (xtal_mode != XMODE_LOW);
    end else if (g == 1) begin : g_lx
      assign src_en[g] = (sel == LEG_CODE[g]) && (xtal_mode == XMODE_LOW);
    end else begin : g_rc
      assign src_en[g] = (sel == LEG_CODE[g]);
    end
  end
endmodule

// File: rtl/sclk_switch_top.sv
module sclk_switch_top
  import sclk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SEL_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0C,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h40,
  parameter int FAIL_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [2:0]        src_stable,
  input  logic [1:0]        xtal_mode,
  output logic [2:0]        sel_code,
  output logic [3:0]        src_en,
  output logic              unlocked,
  output logic [7:0]        status
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  sclk_unlock_seq #(
    .ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR)
  ) u_unlock (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .unlocked(unlocked)
  );

  sclk_sel_ctrl u_sel (
    .clk(clk), .rst_n(rst_sync_n),
    .sel_wr(wr_en && (wr_addr == SEL_ADDR)),
    .sel_wdata(wr_data[2:0]),
    .fail_clr(wr_en && (wr_addr == STAT_ADDR) && wr_data[FAIL_BIT]),
    .unlocked(unlocked), .src_stable(src_stable),
    .sel_q(sel_code), .fail_q(fail_q)
  );

  sclk_src_decode u_dec (
    .sel(sel_code), .xtal_mode(xtal_mode), .src_en(src_en)
  );

  always_comb begin
    status           = '0;
    status[2:0]      = src_stable;
    status[FAIL_BIT] = fail_q;
  end
endmodule

// File: rtl/sclk_switch_chk.sv
module sclk_switch_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SEL_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0C,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [2:0]        src_stable,
  input logic [2:0]        sel_code,
  input logic [3:0]        src_en,
  input logic              unlocked,
  input logic [7:0]        status
);
  function automatic logic chk_ok(input logic [2:0] c);
    return (c == 3'b000) || (c == 3'b011) || (c == 3'b111);
  endfunction

  function automatic logic chk_stb(input logic [2:0] c, input logic [2:0] s);
    return (c == 3'b000) ? s[0] : (c == 3'b011) ? s[1] : (c == 3'b111) ? s[2] : 1'b0;
  endfunction

  logic sel_w, lock_w, clr_w;
  assign sel_w  = wr_en && (wr_addr == SEL_ADDR);
  assign lock_w = wr_en && (wr_addr == LOCK_ADDR);
  assign clr_w  = wr_en && (wr_addr == STAT_ADDR) && wr_data[7];

  assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok(sel_code));

  assert_relock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && lock_w) |=> !unlocked);

  assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && sel_w) |=> ($stable(sel_code) && $stable(status[7])));

  assert_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && sel_w && chk_ok(wr_data[2:0]) &&
     !(chk_stb(wr_data[2:0], src_stable) && chk_stb(sel_code, src_stable)))
    |=> ($stable(sel_code) && status[7]));

  assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_w && !chk_ok(wr_data[2:0])) |=> ($stable(sel_code) && $stable(status[7])));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !clr_w) |=> status[7]);

  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(src_en) == 1);
endmodule

bind sclk_switch_top sclk_switch_chk #(
  .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .STAT_ADDR(STAT_ADDR), .LOCK_ADDR(LOCK_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .src_stable(src_stable), .sel_code(sel_code),
  .src_en(src_en), .unlocked(unlocked), .status(status)
);

// File: tb/test_sclk_switch_top.sv
module test_sclk_switch_top;
  localparam logic [7:0] A_SEL  = 8'h10;
  localparam logic [7:0] A_STAT = 8'h0C;
  localparam logic [7:0] A_LOCK = 8'h40;
  localparam logic [7:0] A_OTH  = 8'h22;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data;
  logic [2:0] src_stable;
  logic [1:0] xtal_mode;
  logic [2:0] sel_code;
  logic [3:0] src_en;
  logic       unlocked;
  logic [7:0] status;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic [2:0] m_sel;
  int         m_stage;
  logic       m_fail;

  sclk_switch_top i_sclk_switch_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src_stable(src_stable), .xtal_mode(xtal_mode), .sel_code(sel_code),
    .src_en(src_en), .unlocked(unlocked), .status(status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic m_valid(input logic [2:0] c);
    return (c == 3'b000) || (c == 3'b011) || (c == 3'b111);
  endfunction

  function automatic logic m_stb(input logic [2:0] c, input logic [2:0] s);
    if (c == 3'b000) return s[0];
    if (c == 3'b011) return s[1];
    if (c == 3'b111) return s[2];
    return 1'b0;
  endfunction

  function automatic logic [3:0] m_en(input logic [2:0] c, input logic [1:0] xm);
    if (c == 3'b111) return 4'b1000;
    if (c == 3'b011) return 4'b0100;
    if (xm == 2'b10) return 4'b0010;
    return 4'b0001;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    check(req, "sel_code", int'(sel_code), int'(m_sel));
    check(req, "unlocked", int'(unlocked), int'(m_stage == 3));
    check(req, "status",   int'(status), int'({m_fail, 4'b0000, src_stable}));
    check(req, "src_en",   int'(src_en), int'(m_en(m_sel, xtal_mode)));
  endtask

  task automatic model_edge();
    bit opn;
    opn = (m_stage == 3);
    if (wr_en) begin
      if (wr_addr == A_LOCK) begin
        case (m_stage)
          0: m_stage = (wr_data == 8'h59) ? 1 : 0;
          1: m_stage = (wr_data == 8'h16) ? 2 : 0;
          2: m_stage = (wr_data == 8'h88) ? 3 : 0;
          default: m_stage = 0;
        endcase
      end else if (m_stage == 1 || m_stage == 2) begin
        m_stage = 0;
      end
      if (wr_addr == A_SEL && opn && m_valid(wr_data[2:0])) begin
        if (m_stb(wr_data[2:0], src_stable) && m_stb(m_sel, src_stable)) m_sel = wr_data[2:0];
        else m_fail = 1'b1;
      end
      if (wr_addr == A_STAT && wr_data[7]) m_fail = 1'b0;
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input string req, input logic we, input logic [7:0] a, input logic [7:0] d);
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wr_en = 1'b0;
    compare_all(req);
  endtask

  task automatic wr(input string req, input logic [7:0] a, input logic [7:0] d);
    step(req, 1'b1, a, d);
  endtask

  task automatic idle(input string req);
    step(req, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic open_lock(input string req);
    wr(req, A_LOCK, 8'h59);
    wr(req, A_LOCK, 8'h16);
    wr(req, A_LOCK, 8'h88);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    src_stable = 3'b111; xtal_mode = 2'b01;
    m_sel = 3'b111; m_stage = 0; m_fail = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare_all("R1");

    // R5: locked select write ignored
    wr("R5", A_SEL, 8'h03);
    idle("R5");
    // R2: unlock
    open_lock("R2");
    // R6 / R10: valid switch to slow RC
    wr("R6", A_SEL, 8'h03);
    idle("R10");
    // R8: reserved codes
    wr("R8", A_SEL, 8'h01);
    wr("R8", A_SEL, 8'h02);
    wr("R8", A_SEL, 8'h05);
    // R7: target (crystal) unstable
    src_stable = 3'b110;
    wr("R7", A_SEL, 8'h00);
    // R9: bit 7 = 0 leaves flag, bit 7 = 1 clears
    wr("R9", A_STAT, 8'h7F);
    idle("R9");
    wr("R9", A_STAT, 8'h80);
    // R6 crystal with high-speed mode, then R10 low-speed branch
    src_stable = 3'b111;
    wr("R6", A_SEL, 8'h00);
    xtal_mode = 2'b10;
    idle("R10");
    xtal_mode = 2'b11;
    idle("R10");
    // R7: current source (crystal) unstable, target fast RC stable
    src_stable = 3'b110;
    wr("R7", A_SEL, 8'h07);
    // R11: stable flags show through
    src_stable = 3'b010;
    idle("R11");
    src_stable = 3'b101;
    idle("R11");
    // R4: relock, then writes are ignored
    src_stable = 3'b111;
    wr("R4", A_LOCK, 8'h59);
    wr("R5", A_SEL, 8'h07);
    // R3: wrong byte restarts
    wr("R3", A_LOCK, 8'h59);
    wr("R3", A_LOCK, 8'h17);
    wr("R3", A_LOCK, 8'h16);
    wr("R3", A_LOCK, 8'h88);
    // R3: foreign address write mid-sequence restarts
    wr("R3", A_LOCK, 8'h59);
    wr("R3", A_OTH,  8'h00);
    wr("R3", A_LOCK, 8'h16);
    wr("R3", A_LOCK, 8'h88);
    wr("R3", A_SEL,  8'h07);
    // R2 again then full switch back to fast RC
    open_lock("R2");
    wr("R6", A_SEL, 8'h07);
    idle("R6");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule